// File: doc/BRIEF.md
# Four-Instruction Load/Store Processor Core

This block is a compact multi-cycle processor for a 32-bit load/store instruction encoding. It recognises four operations. Two work on registers only: addition and subtraction, both modulo 2^32. Two move data between memory and registers: load a word and store a word. Each instruction takes exactly two clock cycles. In the first cycle the word at the program counter is captured into an instruction register. In the second cycle the captured bits drive decode and execution against a 32-entry by 32-bit register file and a byte-addressed data memory. At the end of that second cycle the program counter moves to the next word.

The instruction memory and the data memory both sit outside the core and are read combinationally. The core presents an address and expects the read data within the same cycle. A store raises the write strobe for its single execute cycle only, and the surrounding memory commits the word on that clock edge. Any encoding outside the four supported ones behaves as a no-operation: only the program counter moves. Register 0 is hard-wired to zero.

Top module: `quad_op_core`

## Requirements
- R1: A synchronous reset, sampled high on a clock edge, returns the core to the fetch cycle with the program counter at 0. While reset is held, `dmem_we` stays low. The first instruction after reset is read from address 0.
- R2: Every instruction takes two cycles, a fetch cycle and then an execute cycle. `imem_addr` holds its value across both cycles and increases by 4 after the execute cycle.
- R3: When bits 31:26 are 0 and bits 5:0 are 0x20, the core writes `reg[rs] + reg[rt]` (modulo 2^32) into register rd.
- R4: When bits 31:26 are 0 and bits 5:0 are 0x22, the core writes `reg[rs] - reg[rt]` (modulo 2^32) into register rd. Overflow is ignored.
- R5: When bits 31:26 are 35, the core drives `dmem_addr = reg[rs] + offset` and writes the returned `dmem_rdata` into register rt.
- R6: When bits 31:26 are 43, the core drives `dmem_addr = reg[rs] + offset` and `dmem_wdata = reg[rt]`, and raises `dmem_we` for the single execute cycle. `dmem_we` is never high on any other cycle or for any other opcode.
- R7: The 16-bit offset in bits 15:0 is sign-extended to 32 bits before it is added, so a negative offset addresses below the base register.
- R8: Register 0 always reads as zero. An add, subtract or load that names register 0 as its destination leaves it at zero.
- R9: Any other opcode, or opcode 0 with any other function code, changes no register and no memory word. Only the program counter advances.
- R10: The fields are fixed: op in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, and function in bits 5:0. Bits 10:6 of a register-only instruction do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched or executed (the program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of the data word for a load or store |
| dmem_wdata | output | 32 | Word to be written on a store |
| dmem_we | output | 1 | Store strobe; the word is written on the rising edge that ends the cycle |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The bound checker watches the program counter on every cycle. It checks that the counter returns to zero on reset, holds through the fetch cycle, and steps by four only out of the execute cycle. It also checks that the store strobe appears only in an execute cycle whose captured opcode is the store code, and never twice in a row. Register contents can only be seen through later stores, so the arithmetic results, load return values, sign-extended offsets, the zero register and the silence of unsupported encodings are shown by the bench's instruction sequence. That sequence reads back each result with a store and compares the address and data. A reset in the middle of the run then shows the core restarting from address 0.

// File: rtl/qc_pkg.sv
package qc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_SUB    = 6'h22;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] dest;
        logic [XLEN-1:0] imm;
        logic            reg_we;
        logic            from_mem;
        logic            mem_we;
        logic            alu_sub;
        logic            use_imm;
    } ctrl_t;

    typedef struct packed {
        phase_e          phase;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
    } core_state_t;

endpackage

// File: rtl/qc_decode.sv
module qc_decode
    import qc_pkg::*;
(
    input  logic [XLEN-1:0] ir,
    output ctrl_t           ctrl
);

    logic [5:0] op;
    logic [5:0] fn;

    always_comb begin
        op = ir[31:26];
        fn = ir[5:0];

        ctrl          = '0;
        ctrl.rs       = ir[25:21];
        ctrl.rt       = ir[20:16];
        ctrl.imm      = {{(XLEN-16){ir[15]}}, ir[15:0]};
        ctrl.dest     = ir[15:11];

        unique case (op)
            OPC_REG: begin
                if (fn == FN_ADD || fn == FN_SUB) begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.alu_sub = (fn == FN_SUB);
                end
            end
            OPC_LOAD: begin
                ctrl.dest     = ir[20:16];
                ctrl.reg_we   = 1'b1;
                ctrl.from_mem = 1'b1;
                ctrl.use_imm  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/qc_alu.sv
module qc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/qc_regfile.sv
module qc_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic [$clog2(N)-1:0] ra_a,
    input  logic [$clog2(N)-1:0] ra_b,
    output logic [W-1:0]         rd_a,
    output logic [W-1:0]         rd_b,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);

    localparam int AW = $clog2(N);

    logic [W-1:0] bank [N];

    assign bank[0] = '0;

    for (genvar i = 1; i < N; i++) begin : g_reg
        logic [W-1:0] cell_q;
        logic [W-1:0] cell_d;

        always_comb begin
            cell_d = cell_q;
            if (we && wa == AW'(i)) cell_d = wd;
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign bank[i] = cell_q;
    end

    assign rd_a = bank[ra_a];
    assign rd_b = bank[ra_b];

endmodule

// File: rtl/quad_op_core.sv
module quad_op_core
    import qc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(XLEN / 8);

    core_state_t s_q, s_d;
    ctrl_t       ctrl;
    logic [XLEN-1:0] val_a, val_b, alu_b, alu_y, wb_data;
    logic            in_exec;

    qc_decode u_dec (
        .ir   (s_q.ir),
        .ctrl (ctrl)
    );

    qc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk  (clk),
        .ra_a (ctrl.rs),
        .ra_b (ctrl.rt),
        .rd_a (val_a),
        .rd_b (val_b),
        .we   (in_exec && ctrl.reg_we),
        .wa   (ctrl.dest),
        .wd   (wb_data)
    );

    qc_alu #(.W(XLEN)) u_alu (
        .a   (val_a),
        .b   (alu_b),
        .sub (ctrl.alu_sub),
        .y   (alu_y)
    );

    always_comb begin
        in_exec = (s_q.phase == PH_EXEC);
        alu_b   = ctrl.use_imm ? ctrl.imm : val_b;
        wb_data = ctrl.from_mem ? dmem_rdata : alu_y;

        s_d = s_q;
        unique case (s_q.phase)
            PH_FETCH: begin
                s_d.ir    = imem_rdata;
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.pc    = s_q.pc + PC_STEP;
                s_d.phase = PH_FETCH;
            end
            default: s_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= PH_FETCH;
            s_q.pc    <= RESET_PC;
            s_q.ir    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr  = s_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = val_b;
    assign dmem_we    = in_exec && ctrl.mem_we;

endmodule

module qc_core_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] imem_addr,
    input logic          dmem_we,
    input logic          in_exec,
    input logic [5:0]    ir_op
);

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (imem_addr == '0 && !in_exec));

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> (in_exec && imem_addr == $past(imem_addr)));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_exec |=> (!in_exec && imem_addr == $past(imem_addr) + AW'(4)));

    // R6
    store_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> in_exec);

    // R6
    store_single_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R9
    store_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> ir_op == 6'd43);

endmodule

bind quad_op_core qc_core_chk #(.AW(32)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .in_exec   (s_q.phase == qc_pkg::PH_EXEC),
    .ir_op     (s_q.ir[31:26])
);

// File: tb/test_quad_op_core.sv
module test_quad_op_core;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] off);
        return {op, rs, rt, off};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{enc_i(6'd35, 5'd0, 5'd1, 16'd4),          1'b0, 32'd0,  32'd0},        // R5 r1=5
        '{enc_i(6'd35, 5'd0, 5'd2, 16'd8),          1'b0, 32'd0,  32'd0},        // R5 r2=-2
        '{enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20),     1'b0, 32'd0,  32'd0},        // R3 r3=3
        '{enc_i(6'd43, 5'd0, 5'd3, 16'd32),         1'b1, 32'd32, 32'd3},        // R3 R6
        '{enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h22),     1'b0, 32'd0,  32'd0},        // R4 r4=7
        '{enc_i(6'd43, 5'd0, 5'd4, 16'd36),         1'b1, 32'd36, 32'd7},        // R4
        '{enc_i(6'd35, 5'd0, 5'd5, 16'd12),         1'b0, 32'd0,  32'd0},        // R5
        '{enc_r(5'd5, 5'd1, 5'd6, 5'd0, 6'h22),     1'b0, 32'd0,  32'd0},        // R4 wrap
        '{enc_i(6'd43, 5'd0, 5'd6, 16'd40),         1'b1, 32'd40, 32'h7FFF_FFFB},// R4
        '{enc_i(6'd35, 5'd0, 5'd7, 16'd16),         1'b0, 32'd0,  32'd0},        // R5
        '{enc_r(5'd7, 5'd1, 5'd8, 5'd0, 6'h20),     1'b0, 32'd0,  32'd0},        // R3 wrap
        '{enc_i(6'd43, 5'd0, 5'd8, 16'd44),         1'b1, 32'd44, 32'h8000_0004},// R3
        '{enc_i(6'd35, 5'd0, 5'd9, 16'd20),         1'b0, 32'd0,  32'd0},        // R5 r9=48
        '{enc_i(6'd43, 5'd9, 5'd3, 16'hFFF8),       1'b1, 32'd40, 32'd3},        // R7 store -8
        '{enc_i(6'd35, 5'd9, 5'd11, 16'hFFD4),      1'b0, 32'd0,  32'd0},        // R7 load -44
        '{enc_i(6'd43, 5'd0, 5'd11, 16'd52),        1'b1, 32'd52, 32'd5},        // R7 R5
        '{enc_r(5'd1, 5'd1, 5'd0, 5'd0, 6'h20),     1'b0, 32'd0,  32'd0},        // R8 add to r0
        '{enc_i(6'd43, 5'd0, 5'd0, 16'd56),         1'b1, 32'd56, 32'd0},        // R8
        '{enc_i(6'd35, 5'd0, 5'd0, 16'd4),          1'b0, 32'd0,  32'd0},        // R8 load to r0
        '{enc_i(6'd43, 5'd0, 5'd0, 16'd60),         1'b1, 32'd60, 32'd0},        // R8
        '{enc_i(6'd8, 5'd0, 5'd3, 16'd99),          1'b0, 32'd0,  32'd0},        // R9 bad opcode
        '{enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h24),     1'b0, 32'd0,  32'd0},        // R9 bad funct
        '{enc_i(6'd43, 5'd0, 5'd3, 16'd64),         1'b1, 32'd64, 32'd3},        // R9 r3 kept
        '{enc_r(5'd1, 5'd1, 5'd12, 5'd7, 6'h20),    1'b0, 32'd0,  32'd0},        // R10 shamt set
        '{enc_i(6'd43, 5'd0, 5'd12, 16'd68),        1'b1, 32'd68, 32'd10}        // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] mem [64];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    quad_op_core i_quad_op_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    always_comb begin
        if (imem_addr[31:2] < 30'(NV)) imem_rdata = VEC[imem_addr[6:2]].ins;
        else                           imem_rdata = 32'hFC00_0000;
    end

    assign dmem_rdata = mem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) mem[dmem_addr[7:2]] <= dmem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        mem[1] = 32'd5;
        mem[2] = 32'hFFFF_FFFE;
        mem[3] = 32'h8000_0000;
        mem[4] = 32'h7FFF_FFFF;
        mem[5] = 32'd48;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 we in reset", {31'd0, dmem_we}, 32'd0);
        chk("R1 pc in reset", imem_addr, 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R6 strobe", {31'd0, dmem_we}, {31'd0, VEC[k].we});
            if (VEC[k].we) begin
                chk("R7 store addr", dmem_addr, VEC[k].addr);
                chk("R5 store data", dmem_wdata, VEC[k].data);
            end
            chk("R2 pc held", imem_addr, 32'(4 * k));
            @(posedge clk);
            @(negedge clk);
            chk("R2 pc step", imem_addr, 32'(4 * (k + 1)));
            chk("R6 no strobe in fetch", {31'd0, dmem_we}, 32'd0);
        end

        chk("R7 overwrite below base", mem[10], 32'd3);
        chk("R9 memory untouched", mem[1], 32'd5);
        chk("R9 unused word", mem[18], 32'd0);

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc cleared", imem_addr, 32'd0);
        chk("R1 we low", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 restart addr", imem_addr, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 restart step", imem_addr, 32'd4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule